// File: doc/BRIEF.md
# Bus Transfer Timeout Monitor

This block times every memory or I/O transfer on a processor bus. A transfer begins when the active-low data strobe goes from high to low. From then on the monitor counts rising edges of a slow timer clock, which it first passes through a synchroniser. If the active-low ready signal has not come by the time a set number of those edges has been seen, the transfer is declared hung. The monitor then does three things: it sets a fault bit that depends on whether the transfer was to memory or to I/O, it raises a level 1 pending interrupt request, and it asserts an abort output. That output suppresses the bus strobes and ends the cycle.

The timer clock is not related to the system clock. A transfer can start anywhere inside a timer-clock period, so with two counted edges the hang is detected between one and two timer periods after the strobe falls. The synchroniser adds a few system cycles on top of that. Software can hold the whole mechanism idle and reset through an active-low disable input. The fault bits keep their value until an explicit clear input removes them.

Top module: `bus_tmo_monitor`

## Requirements
- R1: After reset the fault vector is all zero, and the interrupt request and abort outputs are low.
- R2: If `rdy_n` is sampled low while a transfer is being timed, timing stops and that transfer raises no fault, interrupt or abort.
- R3: With `TICKS`=2, an unanswered transfer is flagged no earlier than one timer period and no later than two timer periods (plus `SYNC_STAGES`+2 system cycles) after `strb_n` is sampled falling.
- R4: A timeout on a memory transfer sets bit 8 of `fault_o`. A memory transfer is one where `is_io`=0 when the strobe fall is sampled.
- R5: A timeout on an I/O transfer sets bit 5 of `fault_o`. An I/O transfer is one where `is_io`=1 when the strobe fall is sampled.
- R6: `irq_l1_o` is high for exactly one cycle, and that is the first cycle in which the new fault bit is visible.
- R7: `abort_o` rises together with the interrupt pulse. It stays high until `strb_n` is sampled high and is low at all other times.
- R8: While `tmo_dis_n` is low, no timing takes place and any timing in progress is dropped. No fault, interrupt or abort arises from a strobe fall seen during that time.
- R9: The fault bits are sticky. `flt_clr` clears them, and a set in the same cycle wins over the clear.
- R10: All bits of `fault_o` other than 8 and 5 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_n | input | 1 | Active-low data strobe, synchronous to clk |
| rdy_n | input | 1 | Active-low transfer ready, synchronous to clk |
| is_io | input | 1 | 1 = I/O transfer, 0 = memory transfer |
| tmr_clk | input | 1 | Slow timer clock, asynchronous |
| tmo_dis_n | input | 1 | Active-low disable and reset of the timeout |
| flt_clr | input | 1 | Clears the sticky fault bits |
| fault_o | output | 16 | Fault vector (bit 8 memory, bit 5 I/O) |
| irq_l1_o | output | 1 | Level 1 pending-interrupt request pulse |
| abort_o | output | 1 | Strobe suppress and bus cycle abort |

## Verification
The bench uses the default parameters: `SYNC_STAGES`=2, `TICKS`=2 and a 16-bit fault vector. It drives the timer clock with a period of 16 system cycles. With a timer period that short, a complete timeout takes under 40 cycles, so many transfers fit in one run. It also lets the bench start strobes at different phases of the timer clock, which reaches both the early and the late end of the detection window. Transfers answered just before expiry, disable applied during a transfer, and a clear that coincides with a set are each driven on purpose.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TIME = 2'd1,
        ST_FLT  = 2'd2
    } tmo_st_e;
endpackage

// File: rtl/tmo_sync.sv
module tmo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/tmo_window.sv
module tmo_window
    import tmo_pkg::*;
#(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    input  logic rdy_n,
    input  logic dis_n,
    input  logic is_io,
    input  logic tick,
    output logic expire_mem,
    output logic expire_io,
    output logic abort_o
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        tmo_st_e       st;
        logic [CW-1:0] cnt;
        logic          io;
        logic          strb;
    } win_t;

    win_t w_d, w_q;
    logic fall, expire;

    assign fall = w_q.strb & ~strb_n;

    always_comb begin
        w_d      = w_q;
        w_d.strb = strb_n;
        expire   = 1'b0;
        unique case (w_q.st)
            ST_IDLE: begin
                if (fall && dis_n && rdy_n) begin
                    w_d.st  = ST_TIME;
                    w_d.cnt = '0;
                    w_d.io  = is_io;
                end
            end
            ST_TIME: begin
                if (!dis_n || !rdy_n) begin
                    w_d.st = ST_IDLE;
                end else if (tick) begin
                    if (w_q.cnt == CW'(TICKS - 1)) begin
                        w_d.st = ST_FLT;
                        expire = 1'b1;
                    end else begin
                        w_d.cnt = w_q.cnt + 1'b1;
                    end
                end
            end
            ST_FLT: begin
                if (!dis_n || strb_n) w_d.st = ST_IDLE;
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= '0;
            w_q.st   <= ST_IDLE;
            w_q.strb <= 1'b1;
        end else begin
            w_q <= w_d;
        end
    end

    assign expire_mem = expire & ~w_q.io;
    assign expire_io  = expire &  w_q.io;
    assign abort_o    = (w_q.st == ST_FLT);
endmodule

// File: rtl/tmo_fault_reg.sv
module tmo_fault_reg #(
    parameter int W       = 16,
    parameter int MEM_BIT = 8,
    parameter int IO_BIT  = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_mem,
    input  logic         set_io,
    input  logic         clr,
    output logic [W-1:0] fault_o,
    output logic         irq_o
);
    typedef struct packed {
        logic mem;
        logic io;
        logic irq;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        if (clr) begin
            f_d.mem = 1'b0;
            f_d.io  = 1'b0;
        end
        if (set_mem) f_d.mem = 1'b1;
        if (set_io)  f_d.io  = 1'b1;
        f_d.irq = set_mem | set_io;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        fault_o          = '0;
        fault_o[MEM_BIT] = f_q.mem;
        fault_o[IO_BIT]  = f_q.io;
    end

    assign irq_o = f_q.irq;
endmodule

// File: rtl/bus_tmo_monitor.sv
module bus_tmo_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int TICKS       = 2,
    parameter int FLT_W       = 16,
    parameter int MEM_BIT     = 8,
    parameter int IO_BIT      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_n,
    input  logic             rdy_n,
    input  logic             is_io,
    input  logic             tmr_clk,
    input  logic             tmo_dis_n,
    input  logic             flt_clr,
    output logic [FLT_W-1:0] fault_o,
    output logic             irq_l1_o,
    output logic             abort_o
);
    logic tick, exp_mem, exp_io;

    tmo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(tmr_clk), .rise_o(tick)
    );

    tmo_window #(.TICKS(TICKS)) u_win (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .rdy_n(rdy_n),
        .dis_n(tmo_dis_n), .is_io(is_io), .tick(tick),
        .expire_mem(exp_mem), .expire_io(exp_io), .abort_o(abort_o)
    );

    tmo_fault_reg #(.W(FLT_W), .MEM_BIT(MEM_BIT), .IO_BIT(IO_BIT)) u_flt (
        .clk(clk), .rst_n(rst_n), .set_mem(exp_mem), .set_io(exp_io),
        .clr(flt_clr), .fault_o(fault_o), .irq_o(irq_l1_o)
    );
endmodule

// File: rtl/bus_tmo_monitor_chk.sv
module bus_tmo_monitor_chk #(
    parameter int FLT_W   = 16,
    parameter int MEM_BIT = 8,
    parameter int IO_BIT  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strb_n,
    input logic             tmo_dis_n,
    input logic             flt_clr,
    input logic [FLT_W-1:0] fault_o,
    input logic             irq_l1_o,
    input logic             abort_o
);
    logic [FLT_W-1:0] mask;
    always_comb begin
        mask          = '0;
        mask[MEM_BIT] = 1'b1;
        mask[IO_BIT]  = 1'b1;
    end

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l1_o |=> !irq_l1_o);
    p_irq_has_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l1_o |-> (fault_o[MEM_BIT] || fault_o[IO_BIT]));
    p_irq_with_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l1_o |-> abort_o);
    p_abort_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !strb_n && tmo_dis_n) |=> abort_o);
    p_dis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_dis_n |=> (!irq_l1_o && !abort_o));
    p_sticky_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o[MEM_BIT] && !flt_clr) |=> fault_o[MEM_BIT]);
    p_sticky_io_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o[IO_BIT] && !flt_clr) |=> fault_o[IO_BIT]);
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o & ~mask) == '0);
endmodule

bind bus_tmo_monitor bus_tmo_monitor_chk #(
    .FLT_W(FLT_W), .MEM_BIT(MEM_BIT), .IO_BIT(IO_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .tmo_dis_n(tmo_dis_n),
    .flt_clr(flt_clr), .fault_o(fault_o), .irq_l1_o(irq_l1_o),
    .abort_o(abort_o)
);

// File: tb/sim_bus_tmo_monitor.sv
`timescale 1ns/1ps
module sim_bus_tmo_monitor;
    localparam int SYNC = 2;
    localparam int TPER = 16;

    logic clk = 0, rst_n = 0;
    logic strb_n = 1, rdy_n = 1, is_io = 0, tmr_clk = 0, tmo_dis_n = 1, flt_clr = 0;
    logic [15:0] fault_o;
    logic irq_l1_o, abort_o;

    int vectors = 0, errors = 0, cyc = 0;

    always #2 clk = ~clk;

    bus_tmo_monitor u0 (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .rdy_n(rdy_n), .is_io(is_io),
        .tmr_clk(tmr_clk), .tmo_dis_n(tmo_dis_n), .flt_clr(flt_clr),
        .fault_o(fault_o), .irq_l1_o(irq_l1_o), .abort_o(abort_o)
    );

    // timer clock: half period TPER/2 system cycles, changes after posedge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc % (TPER / 2) == 0) tmr_clk <= #1 ~tmr_clk;
    end

    // behavioural reference model
    bit hist[$];
    int m_state = 0, m_edges = 0;
    bit m_io = 0, m_prev_strb = 1, m_mem_f = 0, m_io_f = 0, m_irq = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
            m_state = 0; m_edges = 0; m_prev_strb = 1;
            m_mem_f = 0; m_io_f = 0; m_irq = 0;
        end else begin
            bit rising, timeout;
            rising  = hist[SYNC-1] && !hist[SYNC];
            timeout = 0;
            if (m_state == 0) begin
                if (m_prev_strb && !strb_n && tmo_dis_n && rdy_n) begin
                    m_state = 1; m_edges = 0; m_io = is_io;
                end
            end else if (m_state == 1) begin
                if (!tmo_dis_n || !rdy_n) m_state = 0;
                else if (rising) begin
                    m_edges++;
                    if (m_edges == 2) begin timeout = 1; m_state = 2; end
                end
            end else begin
                if (!tmo_dis_n || strb_n) m_state = 0;
            end
            if (flt_clr) begin m_mem_f = 0; m_io_f = 0; end
            if (timeout && !m_io) m_mem_f = 1;
            if (timeout &&  m_io) m_io_f = 1;
            m_irq = timeout;
            m_prev_strb = strb_n;
            hist.push_front(tmr_clk);
            void'(hist.pop_back());
        end
    end

    // compare away from the active edge
    always @(negedge clk) if (rst_n) begin
        logic [15:0] expf;
        expf = '0; expf[8] = m_mem_f; expf[5] = m_io_f;
        vectors++;
        if (fault_o !== expf) begin
            errors++;
            $display("FAIL R4/R5/R9/R10 fault_o=%h expected %h at cycle %0d", fault_o, expf, cyc);
        end
        if (irq_l1_o !== m_irq) begin
            errors++;
            $display("FAIL R6 irq_l1_o=%b expected %b at cycle %0d", irq_l1_o, m_irq, cyc);
        end
        if (abort_o !== (m_state == 2)) begin
            errors++;
            $display("FAIL R7 abort_o=%b expected %b at cycle %0d", abort_o, (m_state == 2), cyc);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // start a transfer, wait for the interrupt, return latency in cycles
    task automatic hung(bit io, output int lat);
        is_io = io; strb_n = 0;
        lat = 0;
        while (!irq_l1_o && lat < 4 * TPER) begin step(1); lat++; end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int lat;
        step(3);
        // R1 reset state
        check("R1 fault", fault_o, 0);
        check("R1 irq", irq_l1_o, 0);
        check("R1 abort", abort_o, 0);
        rst_n = 1;
        step(5);

        // R4 memory timeout + R3 window, several phases
        for (int ph = 0; ph < 6; ph++) begin
            step(ph * 3);
            hung(0, lat);
            check("R3 lower bound", lat >= TPER, 1);
            check("R3 upper bound", lat <= 2 * TPER + SYNC + 2, 1);
            check("R4 mem bit", fault_o[8], 1);
            check("R6 irq pulse", irq_l1_o, 1);
            check("R7 abort", abort_o, 1);
            step(4);
            check("R7 abort held", abort_o, 1);
            check("R6 irq single", irq_l1_o, 0);
            strb_n = 1; step(2);
            check("R7 abort released", abort_o, 0);
            flt_clr = 1; step(1); flt_clr = 0;
            check("R9 clear", fault_o, 0);
        end

        // R5 I/O timeout
        hung(1, lat);
        check("R5 io bit", fault_o, 16'h0020);
        strb_n = 1; step(3);
        check("R9 sticky", fault_o, 16'h0020);

        // R2 ready before deadline
        is_io = 0; strb_n = 0; step(TPER - 2);
        rdy_n = 0; step(1); rdy_n = 1; step(3 * TPER);
        check("R2 no fault", fault_o, 16'h0020);
        check("R2 no abort", abort_o, 0);
        strb_n = 1; step(2);

        // R8 disable during transfer
        strb_n = 0; step(5); tmo_dis_n = 0; step(1); tmo_dis_n = 1;
        step(3 * TPER);
        check("R8 dropped", fault_o, 16'h0020);
        check("R8 no abort", abort_o, 0);
        strb_n = 1; step(2);
        // R8 fall while disabled
        tmo_dis_n = 0; strb_n = 0; step(2); tmo_dis_n = 1; step(3 * TPER);
        check("R8 no start", fault_o, 16'h0020);
        strb_n = 1; step(2);

        // R9 set beats clear
        hung(0, lat);
        check("R4 mem with io", fault_o, 16'h0120);
        strb_n = 1; flt_clr = 1; step(1); flt_clr = 0;
        check("R9 cleared", fault_o, 0);
        strb_n = 0; lat = 0;
        while (lat < 4 * TPER) begin
            // raise clear in the cycle whose edge sets the bit
            if (u0.abort_o) break;
            flt_clr = 1; step(1); lat++;
        end
        flt_clr = 0;
        check("R9 set wins", fault_o[8], 1);
        check("R10 unused bits", fault_o & ~16'h0120, 0);
        strb_n = 1; step(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule